// File: doc/BRIEF.md
# Port-Group Forwarding Resolver

This block decides where a switched frame leaves. It holds one table of port-group masks and reads it three times per frame. The three reads are a destination group, an aggregation group and a source group. The egress mask is the bitwise AND of the three. Each mask has one bit per physical port plus one bit for the CPU port, which sits directly above the physical ports.

The destination row comes from the MAC table result when the lookup hits. On a miss it is a flood row chosen by the frame class. The aggregation row is picked by a 4-bit flow code, so that only one member of a link bundle carries the flow. The source row is picked by the ingress port and says which egress ports that port may reach. Software fills the table through a simple write/read port.

Requests enter one per cycle. Each result appears on a registered mask output with a valid strobe, a fixed two cycles later.

Top module: `pgfwd_resolver`

## Requirements
- R1: After reset every table row reads as zero, and `fwd_valid`, `fwd_mask`, `cfg_rdata` and `src_err` are all zero.
- R2: A write with `cfg_wr_en` to a row below 91 stores `cfg_wdata` in that row. A read with `cfg_rd_en` presents that row on `cfg_rdata` after the next clock edge, and the value holds until the next read.
- R3: A write to a row of 91 or above changes no row. A read of such a row returns zero.
- R4: When `req_mac_hit` is 1, the destination row is `req_dest_idx` (0 to 63), used directly.
- R5: When `req_mac_hit` is 0, the destination row depends on `req_class`. Class 0 (unknown unicast) uses row 59, class 1 (non-IP multicast) uses 60, class 2 (IPv4 multicast) uses 61, class 3 (IPv6 multicast) uses 62 and class 4 (broadcast) uses 63. Classes 5 to 7 use the drop row 57.
- R6: The aggregation row is 64 plus `req_aggr_code`.
- R7: The source row is 80 plus `req_src_port`.
- R8: `fwd_mask` is the bitwise AND of the destination, aggregation and source rows. Bit N (N = 11 physical ports) is the CPU port.
- R9: A request accepted at clock edge k gives `fwd_valid` = 1 after edge k+1. Back-to-back requests give back-to-back results.
- R10: Each request uses the table contents from before the edge that accepts it. A write at that same edge affects only later requests.
- R11: A request with `req_src_port` of 11 or above gives an all-zero mask. It also sets `src_err`, which stays set until reset.
- R12: `fwd_mask` is zero whenever `fwd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_rd_en | input | 1 | Table read strobe |
| cfg_addr | input | 7 | Table row for a write or a read |
| cfg_wdata | input | 12 | Mask to write |
| cfg_rdata | output | 12 | Mask read back |
| req_valid | input | 1 | Lookup request strobe |
| req_src_port | input | 4 | Ingress port number |
| req_mac_hit | input | 1 | MAC table hit |
| req_dest_idx | input | 6 | Destination row on a hit |
| req_class | input | 3 | Frame class used on a miss |
| req_aggr_code | input | 4 | Link aggregation flow code |
| fwd_valid | output | 1 | Result strobe |
| fwd_mask | output | 12 | Egress port mask, CPU at bit 11 |
| src_err | output | 1 | Sticky flag for an out-of-range ingress port |

## Verification
The bench fills the table with masks where each lookup removes different bits. As a result, a wrong row choice, a missing AND term or a swapped flood row leaves a wrong bit in the mask. A design that used the current write instead of the old row in the same-cycle case would return the new destination mask one request early. Writes and reads at rows 95 and 90 catch a design that folds wide addresses onto real rows. A bad ingress port must zero the mask and raise a flag that stays set after later good requests. A design that read a row past the source region, or cleared the flag, would show up there. Requests streamed back to back expose a result that is one cycle late or held over from the previous request.

// File: rtl/pgfwd_pkg.sv
package pgfwd_pkg;

  // Fixed row regions of the group table
  localparam int unsigned ROW_DROP     = 57;
  localparam int unsigned ROW_TO_CPU   = 58;
  localparam int unsigned ROW_FLOOD_UC = 59;
  localparam int unsigned ROW_FLOOD_L2 = 60;
  localparam int unsigned ROW_FLOOD_V4 = 61;
  localparam int unsigned ROW_FLOOD_V6 = 62;
  localparam int unsigned ROW_FLOOD_BC = 63;
  localparam int unsigned CODE_W       = 4;
  localparam int unsigned AGG_BASE     = 64;
  localparam int unsigned AGG_ROWS     = 1 << CODE_W;
  localparam int unsigned SRC_BASE     = AGG_BASE + AGG_ROWS;

  typedef enum logic [2:0] {
    FC_UCAST = 3'd0,
    FC_L2MC  = 3'd1,
    FC_MC4   = 3'd2,
    FC_MC6   = 3'd3,
    FC_BCAST = 3'd4
  } fclass_e;

  function automatic int unsigned flood_row(input logic [2:0] cls);
    int unsigned row;
    case (cls)
      FC_UCAST: row = ROW_FLOOD_UC;
      FC_L2MC:  row = ROW_FLOOD_L2;
      FC_MC4:   row = ROW_FLOOD_V4;
      FC_MC6:   row = ROW_FLOOD_V6;
      FC_BCAST: row = ROW_FLOOD_BC;
      default:  row = ROW_DROP;
    endcase
    return row;
  endfunction

endpackage

// File: rtl/pgfwd_rst_sync.sv
module pgfwd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pgfwd_index.sv
module pgfwd_index #(
  parameter int NPORTS = 11,
  parameter int AW     = 7,
  parameter int PORT_W = 4,
  parameter int DIDX_W = 6
) (
  input  logic [PORT_W-1:0]              src_port,
  input  logic                           mac_hit,
  input  logic [DIDX_W-1:0]              dest_idx,
  input  logic [2:0]                     fclass,
  input  logic [pgfwd_pkg::CODE_W-1:0]   aggr_code,
  output logic [AW-1:0]                  dst_row,
  output logic [AW-1:0]                  agg_row,
  output logic [AW-1:0]                  src_row,
  output logic                           port_bad
);

  always_comb begin
    if (mac_hit) dst_row = AW'(dest_idx);
    else         dst_row = AW'(pgfwd_pkg::flood_row(fclass));
  end

  always_comb begin
    agg_row  = AW'(pgfwd_pkg::AGG_BASE) + AW'(aggr_code);
    port_bad = (int'(src_port) >= NPORTS);
    if (port_bad) src_row = AW'(pgfwd_pkg::SRC_BASE);
    else          src_row = AW'(pgfwd_pkg::SRC_BASE) + AW'(src_port);
  end

endmodule

// File: rtl/pgfwd_table.sv
module pgfwd_table #(
  parameter int DEPTH  = 91,
  parameter int MASK_W = 12,
  parameter int AW     = 7,
  parameter int NRD    = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [MASK_W-1:0]            wr_data,
  input  logic [NRD-1:0][AW-1:0]       rd_addr,
  output logic [NRD-1:0][MASK_W-1:0]   rd_data
);

  logic [DEPTH-1:0][MASK_W-1:0] rows;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic              we;
    logic [MASK_W-1:0] q;
    logic [MASK_W-1:0] d;

    always_comb begin
      we = wr_en && (wr_addr == AW'(r));
      d  = we ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign rows[r] = q;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          in_range;
    logic [AW-1:0] safe_addr;

    always_comb begin
      in_range  = (int'(rd_addr[p]) < DEPTH);
      safe_addr = in_range ? rd_addr[p] : '0;
      rd_data[p] = in_range ? rows[safe_addr] : '0;
    end
  end

endmodule

// File: rtl/pgfwd_resolver.sv
module pgfwd_resolver #(
  parameter int NPORTS = 11,
  parameter int MASK_W = NPORTS + 1,
  parameter int DIDX_W = 6,
  parameter int PORT_W = $clog2(NPORTS),
  parameter int TBL_AW = $clog2(pgfwd_pkg::SRC_BASE + NPORTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr_en,
  input  logic                          cfg_rd_en,
  input  logic [TBL_AW-1:0]             cfg_addr,
  input  logic [MASK_W-1:0]             cfg_wdata,
  output logic [MASK_W-1:0]             cfg_rdata,
  input  logic                          req_valid,
  input  logic [PORT_W-1:0]             req_src_port,
  input  logic                          req_mac_hit,
  input  logic [DIDX_W-1:0]             req_dest_idx,
  input  logic [2:0]                    req_class,
  input  logic [pgfwd_pkg::CODE_W-1:0]  req_aggr_code,
  output logic                          fwd_valid,
  output logic [MASK_W-1:0]             fwd_mask,
  output logic                          src_err
);

  localparam int DEPTH  = pgfwd_pkg::SRC_BASE + NPORTS;
  localparam int NRD    = 4;
  localparam int RD_DST = 0;
  localparam int RD_AGG = 1;
  localparam int RD_SRC = 2;
  localparam int RD_CFG = 3;

  logic rst_q;

  pgfwd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  // Row selection
  logic [TBL_AW-1:0] dst_row, agg_row, src_row;
  logic              port_bad;

  pgfwd_index #(
    .NPORTS (NPORTS),
    .AW     (TBL_AW),
    .PORT_W (PORT_W),
    .DIDX_W (DIDX_W)
  ) u_idx (
    .src_port  (req_src_port),
    .mac_hit   (req_mac_hit),
    .dest_idx  (req_dest_idx),
    .fclass    (req_class),
    .aggr_code (req_aggr_code),
    .dst_row   (dst_row),
    .agg_row   (agg_row),
    .src_row   (src_row),
    .port_bad  (port_bad)
  );

  // Shared group table
  logic [NRD-1:0][TBL_AW-1:0] rd_addr;
  logic [NRD-1:0][MASK_W-1:0] rd_data;

  always_comb begin
    rd_addr[RD_DST] = dst_row;
    rd_addr[RD_AGG] = agg_row;
    rd_addr[RD_SRC] = src_row;
    rd_addr[RD_CFG] = cfg_addr;
  end

  pgfwd_table #(
    .DEPTH  (DEPTH),
    .MASK_W (MASK_W),
    .AW     (TBL_AW),
    .NRD    (NRD)
  ) u_tbl (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // Stage 1: captured lookups
  logic              s1_vld_q, s1_vld_d;
  logic              s1_bad_q, s1_bad_d;
  logic [MASK_W-1:0] s1_dst_q, s1_dst_d;
  logic [MASK_W-1:0] s1_agg_q, s1_agg_d;
  logic [MASK_W-1:0] s1_src_q, s1_src_d;
  logic              s1_en;

  always_comb begin
    s1_en    = req_valid || s1_vld_q;
    s1_vld_d = req_valid;
    s1_bad_d = req_valid && port_bad;
    s1_dst_d = req_valid ? rd_data[RD_DST] : '0;
    s1_agg_d = req_valid ? rd_data[RD_AGG] : '0;
    s1_src_d = req_valid ? rd_data[RD_SRC] : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld_q <= 1'b0;
      s1_bad_q <= 1'b0;
      s1_dst_q <= '0;
      s1_agg_q <= '0;
      s1_src_q <= '0;
    end else if (s1_en) begin
      s1_vld_q <= s1_vld_d;
      s1_bad_q <= s1_bad_d;
      s1_dst_q <= s1_dst_d;
      s1_agg_q <= s1_agg_d;
      s1_src_q <= s1_src_d;
    end
  end

  // Stage 2: combine
  logic              out_vld_q, out_vld_d;
  logic [MASK_W-1:0] out_mask_q, out_mask_d;
  logic              s2_en;

  always_comb begin
    s2_en     = s1_vld_q || out_vld_q;
    out_vld_d = s1_vld_q;
    if (s1_vld_q && !s1_bad_q) out_mask_d = s1_dst_q & s1_agg_q & s1_src_q;
    else                       out_mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_vld_q  <= 1'b0;
      out_mask_q <= '0;
    end else if (s2_en) begin
      out_vld_q  <= out_vld_d;
      out_mask_q <= out_mask_d;
    end
  end

  // Sticky ingress-range flag
  logic err_q, err_d;

  always_comb begin
    err_d = err_q || (req_valid && port_bad);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  // Configuration read-back
  logic [MASK_W-1:0] rdat_q, rdat_d;

  always_comb begin
    rdat_d = rd_data[RD_CFG];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)         rdat_q <= '0;
    else if (cfg_rd_en) rdat_q <= rdat_d;
  end

  assign fwd_valid = out_vld_q;
  assign fwd_mask  = out_mask_q;
  assign src_err   = err_q;
  assign cfg_rdata = rdat_q;

endmodule

// File: rtl/pgfwd_resolver_chk.sv
module pgfwd_resolver_chk #(
  parameter int NPORTS = 11,
  parameter int MASK_W = NPORTS + 1,
  parameter int PORT_W = 4,
  parameter int TBL_AW = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [PORT_W-1:0] req_src_port,
  input logic              cfg_rd_en,
  input logic [TBL_AW-1:0] cfg_addr,
  input logic              fwd_valid,
  input logic [MASK_W-1:0] fwd_mask,
  input logic              src_err,
  input logic [MASK_W-1:0] cfg_rdata
);

  localparam int DEPTH = pgfwd_pkg::SRC_BASE + NPORTS;

  logic [1:0] vld_sh;
  logic [1:0] bad_sh;
  logic       oor_rd_q;
  logic       oor_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sh     <= 2'b00;
      bad_sh     <= 2'b00;
      oor_rd_q   <= 1'b0;
      oor_hold_q <= 1'b0;
    end else begin
      vld_sh   <= {vld_sh[0], req_valid};
      bad_sh   <= {bad_sh[0], req_valid && (int'(req_src_port) >= NPORTS)};
      oor_rd_q <= cfg_rd_en && (int'(cfg_addr) >= DEPTH);
      if (cfg_rd_en) oor_hold_q <= (int'(cfg_addr) >= DEPTH);
    end
  end

  // R9: result two edges after acceptance
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid == vld_sh[1]);

  // R11: bad ingress gives empty mask
  assert_badport_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && bad_sh[1]) |-> (fwd_mask == '0));

  // R11: flag raised once a bad port was accepted
  assert_err_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sh[0] |-> src_err);

  // R11: flag is sticky
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> src_err);

  // R12: no mask without a strobe
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_valid |-> (fwd_mask == '0));

  // R3: rows past the table read as zero
  assert_oor_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_rd_q || oor_hold_q) |-> (cfg_rdata == '0));

endmodule

bind pgfwd_resolver pgfwd_resolver_chk #(
  .NPORTS (NPORTS),
  .MASK_W (MASK_W),
  .PORT_W (PORT_W),
  .TBL_AW (TBL_AW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_q),
  .req_valid    (req_valid),
  .req_src_port (req_src_port),
  .cfg_rd_en    (cfg_rd_en),
  .cfg_addr     (cfg_addr),
  .fwd_valid    (fwd_valid),
  .fwd_mask     (fwd_mask),
  .src_err      (src_err),
  .cfg_rdata    (cfg_rdata)
);

// File: tb/pgfwd_resolver_tb_top.sv
module pgfwd_resolver_tb_top;

  localparam int NV = 16;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic        cfg_rd_en;
  logic [6:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic [11:0] cfg_rdata;
  logic        req_valid;
  logic [3:0]  req_src_port;
  logic        req_mac_hit;
  logic [5:0]  req_dest_idx;
  logic [2:0]  req_class;
  logic [3:0]  req_aggr_code;
  logic        fwd_valid;
  logic [11:0] fwd_mask;
  logic        src_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  pgfwd_resolver dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_en     (cfg_wr_en),
    .cfg_rd_en     (cfg_rd_en),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .req_valid     (req_valid),
    .req_src_port  (req_src_port),
    .req_mac_hit   (req_mac_hit),
    .req_dest_idx  (req_dest_idx),
    .req_class     (req_class),
    .req_aggr_code (req_aggr_code),
    .fwd_valid     (fwd_valid),
    .fwd_mask      (fwd_mask),
    .src_err       (src_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {port, hit, dest_idx, class, aggr_code, expected mask}
  // Covers R4 (hit rows), R5 (flood rows), R6 (aggr codes), R7 (source rows), R8 (AND)
  localparam logic [29:0] VEC [NV] = '{
    {4'd0,  1'b1, 6'd3,  3'd0, 4'd0, 12'h008},
    {4'd3,  1'b1, 6'd3,  3'd0, 4'd0, 12'h000},
    {4'd1,  1'b1, 6'd11, 3'd0, 4'd0, 12'h0F1},
    {4'd1,  1'b1, 6'd11, 3'd0, 4'd5, 12'h0F0},
    {4'd4,  1'b0, 6'd0,  3'd0, 4'd0, 12'h7EF},
    {4'd4,  1'b0, 6'd0,  3'd1, 4'd0, 12'h0AA},
    {4'd4,  1'b0, 6'd0,  3'd2, 4'd0, 12'h045},
    {4'd0,  1'b0, 6'd0,  3'd3, 4'd0, 12'h300},
    {4'd0,  1'b0, 6'd0,  3'd4, 4'd3, 12'hFFC},
    {4'd2,  1'b0, 6'd0,  3'd4, 4'd0, 12'h800},
    {4'd5,  1'b1, 6'd58, 3'd0, 4'd0, 12'h800},
    {4'd5,  1'b1, 6'd57, 3'd0, 4'd0, 12'h000},
    {4'd10, 1'b0, 6'd0,  3'd5, 4'd0, 12'h000},
    {4'd10, 1'b1, 6'd1,  3'd0, 4'd3, 12'h000},
    {4'd10, 1'b1, 6'd0,  3'd0, 4'd0, 12'h001},
    {4'd6,  1'b1, 6'd59, 3'd2, 4'd0, 12'h7BF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = 7'(a);
    cfg_wdata = d;
    @(posedge clk);
    #1 cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [11:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1;
    cfg_addr  = 7'(a);
    @(posedge clk);
    #1 cfg_rd_en = 1'b0;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic drive_vec(input logic [29:0] v);
    req_valid     = 1'b1;
    req_src_port  = v[29:26];
    req_mac_hit   = v[25];
    req_dest_idx  = v[24:19];
    req_class     = v[18:16];
    req_aggr_code = v[15:12];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] d;
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; cfg_rd_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_src_port = '0; req_mac_hit = 1'b0;
    req_dest_idx = '0; req_class = '0; req_aggr_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 fwd_valid", 32'(fwd_valid), 32'd0);
    chk("R1 fwd_mask", 32'(fwd_mask), 32'd0);
    chk("R1 src_err", 32'(src_err), 32'd0);
    rd(59, d);
    chk("R1 row59", 32'(d), 32'd0);

    // Table fill
    for (int i = 0; i < 11; i++) wr(i, 12'(1 << i));
    wr(11, 12'h0F3);
    wr(57, 12'h000);
    wr(58, 12'h800);
    wr(59, 12'h7FF);
    wr(60, 12'h0AA);
    wr(61, 12'h055);
    wr(62, 12'h300);
    wr(63, 12'hFFF);
    for (int c = 0; c < 16; c++) wr(64 + c, 12'hFFF);
    wr(67, 12'hFFD);
    wr(69, 12'hFFE);
    for (int p = 0; p < 11; p++) wr(80 + p, 12'hFFF & ~12'(1 << p));
    wr(82, 12'h800);

    // R2: read-back
    rd(11, d);
    chk("R2 row11", 32'(d), 32'h0F3);
    rd(85, d);
    chk("R2 row85", 32'(d), 32'hFDF);

    // R3: out-of-range write ignored, read zero
    wr(95, 12'hABC);
    rd(95, d);
    chk("R3 read row95", 32'(d), 32'd0);
    rd(90, d);
    chk("R3 row90 untouched", 32'(d), 32'hBFF);
    rd(31, d);
    chk("R3 row31 untouched", 32'(d), 32'd0);

    // R9: vectors streamed one per cycle
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R9 valid vec %0d", i - 2), 32'(fwd_valid), 32'd1);
        chk($sformatf("R4/R5/R6/R7/R8 mask vec %0d", i - 2), 32'(fwd_mask), 32'(VEC[i-2][11:0]));
      end
      if (i < NV) drive_vec(VEC[i]);
      else        req_valid = 1'b0;
    end

    // R12: idle after stream
    @(negedge clk);
    chk("R12 idle valid", 32'(fwd_valid), 32'd0);
    chk("R12 idle mask", 32'(fwd_mask), 32'd0);

    // R10: write and request on the same edge
    @(negedge clk);
    drive_vec({4'd0, 1'b1, 6'd3, 3'd0, 4'd0, 12'h000});
    cfg_wr_en = 1'b1; cfg_addr = 7'd3; cfg_wdata = 12'h010;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 old row used", 32'(fwd_mask), 32'h008);
    @(negedge clk);
    chk("R10 new row next", 32'(fwd_mask), 32'h010);

    // R11: bad ingress port
    @(negedge clk);
    drive_vec({4'd11, 1'b0, 6'd0, 3'd4, 4'd0, 12'h000});
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 bad valid", 32'(fwd_valid), 32'd1);
    chk("R11 bad mask", 32'(fwd_mask), 32'd0);
    chk("R11 err set", 32'(src_err), 32'd1);
    drive_vec({4'd0, 1'b1, 6'd3, 3'd0, 4'd0, 12'h000});
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 good after bad", 32'(fwd_mask), 32'h010);
    chk("R11 err sticky", 32'(src_err), 32'd1);

    finish_run();
  end

endmodule